// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block takes a two's complement word that arrives one bit per valid cycle, least significant bit first, and emits the arithmetic negative of that word in the same bit order. Each output bit follows its input bit after one clock. The caller frames each word with two strobes. A first-bit strobe rides with bit 0, and a final-bit strobe rides with the sign bit. Cycles with the valid input low carry no bit and may fall anywhere, including inside a word.

The negation uses a single state bit that records whether a 1 has already passed in the current word. Bits up to and including the first 1 are copied through. Every bit after that is inverted. When the sign bit goes out, the block also marks the end of the word. It raises a zero flag when the word held no 1 at all. It raises an overflow flag when the only 1 was the sign bit, because that value, the most negative one, has no positive counterpart.

Top module: `negser_top`

## Requirements
- R1: Within a word, each input bit that is 0 and comes before the first 1 appears unchanged on the output.
- R2: The first 1 of a word appears unchanged on the output, and every later bit of that word appears inverted.
- R3: Over a complete word of WIDTH bits, the output bits equal the bitwise inverse of the input word plus one, modulo 2^WIDTH. Zero maps to zero.
- R4: The overflow flag is 1 in the output cycle of the final bit exactly when the input word is a 1 in the sign bit followed by all zeros. In that case the output pattern equals the input pattern. The flag is 0 in every other cycle.
- R5: The zero flag is 1 in the output cycle of the final bit exactly when every bit of the word was 0, and it is 0 in every other cycle. The zero flag and the overflow flag are never 1 together.
- R6: The done output is a single-cycle pulse. It is 1 exactly in the output cycle of the bit that carried the final-bit strobe, and that bit must be bit WIDTH-1 of the word.
- R7: The output valid equals the input valid of the previous cycle. The output bit and the flags appear one clock after their input bit.
- R8: The first-bit strobe clears the first-one state. Words may follow one another with no idle cycle, and no state carries from one word into the next.
- R9: While synchronous active-high reset is held, and in the first output cycle after it, all outputs are 0.
- R10: A cycle with the input valid low does not change the word's state or position. A word with idle cycles between its bits gives the same output bits and flags as the same word sent without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The current cycle carries an input bit |
| in_bit | input | 1 | Input data bit, least significant bit first |
| in_start | input | 1 | Marks bit 0 of a word |
| in_last | input | 1 | Marks bit WIDTH-1 (the sign bit) of a word |
| out_valid | output | 1 | The current cycle carries an output bit |
| out_bit | output | 1 | Negated data bit |
| out_done | output | 1 | Pulse with the final output bit of a word |
| out_zero | output | 1 | The finished word was zero |
| out_ovf | output | 1 | The finished word was the most negative value |

## Verification
The final-bit output can carry the last negated bit, the done pulse and one of the two flags in one cycle. In a back-to-back stream, that same cycle is followed at once by bit 0 of the next word, which must start with cleared state. The bench provokes this by sending the zero word and the most negative word next to each other and between other words with no idle cycle. It also sweeps every 8-bit value with no gaps. A behavioural model computes each expected output from the integer negation of the word, and it compares every output field on every clock. That comparison catches a flag that leaks into a neighbouring cycle or a first-one state that survives a word boundary.

// File: rtl/negser_pkg.sv
package negser_pkg;
  // End-of-word status carried alongside the final output bit
  typedef struct packed {
    logic done;
    logic zero;
    logic ovf;
  } word_stat_t;

  localparam word_stat_t STAT_IDLE = '{done: 1'b0, zero: 1'b0, ovf: 1'b0};
endpackage

// File: rtl/negser_xform.sv
// Copy-until-first-one transform with a single state bit
module negser_xform (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_start,
  output logic seen_before,
  output logic out_bit
);
  logic seen_q;

  // state as seen by the current bit: a start strobe forgets earlier words
  assign seen_before = in_start ? 1'b0 : seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      out_bit <= 1'b0;
    end else if (in_valid) begin
      seen_q  <= seen_before | in_bit;
      out_bit <= in_bit ^ seen_before;
    end else begin
      out_bit <= 1'b0;
    end
  end

  // first bit of a word always passes unchanged
  AST_FIRST_BIT_COPIED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start) |=> (out_bit == $past(in_bit))); // R1

  // a gap cycle drives no data
  AST_IDLE_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_bit); // R10
endmodule

// File: rtl/negser_flags.sv
// Word position tracking and end-of-word status
module negser_flags
  import negser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_start,
  input  logic       in_last,
  input  logic       seen_before,
  output logic       out_valid,
  output word_stat_t stat
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(WIDTH - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_eff;
  logic          closing;

  assign pos_eff = in_start ? '0 : pos_q;
  assign closing = in_valid && in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      out_valid <= 1'b0;
      stat      <= STAT_IDLE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        pos_q <= closing ? '0 : pos_eff + PW'(1);
      end
      stat.done <= closing;
      stat.zero <= closing && !seen_before && !in_bit;
      stat.ovf  <= closing && !seen_before && in_bit;
    end
  end

  AST_LAST_AT_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
    closing |-> (pos_eff == LAST_POS)); // R6

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stat.done |=> !stat.done || $past(closing)); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(stat.zero && stat.ovf)); // R5

  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (stat.zero || stat.ovf) |-> (stat.done && out_valid)); // R4
endmodule

// File: rtl/negser_top.sv
module negser_top
  import negser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_start,
  input  logic in_last,
  output logic out_valid,
  output logic out_bit,
  output logic out_done,
  output logic out_zero,
  output logic out_ovf
);
  logic       seen_before;
  word_stat_t stat;

  negser_xform u_xform (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .in_start    (in_start),
    .seen_before (seen_before),
    .out_bit     (out_bit)
  );

  negser_flags #(.WIDTH(WIDTH)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .in_start    (in_start),
    .in_last     (in_last),
    .seen_before (seen_before),
    .out_valid   (out_valid),
    .stat        (stat)
  );

  assign out_done = stat.done;
  assign out_zero = stat.zero;
  assign out_ovf  = stat.ovf;

  AST_DATA_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_bit || out_done) |-> out_valid); // R7
endmodule

// File: tb/test_negser_top.sv
module test_negser_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic out_valid, out_bit, out_done, out_zero, out_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // expected outputs for the next negedge
  logic e_v = 1'b0, e_b = 1'b0, e_d = 1'b0, e_z = 1'b0, e_o = 1'b0;
  string e_tag = "R9";

  always #5 clk = ~clk;

  negser_top #(.WIDTH(W)) i_negser_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_start(in_start), .in_last(in_last), .out_valid(out_valid),
    .out_bit(out_bit), .out_done(out_done), .out_zero(out_zero), .out_ovf(out_ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    chk(out_valid, e_v, "R7", "out_valid");
    chk(out_bit,   e_b, e_tag, "out_bit");
    chk(out_done,  e_d, "R6", "out_done");
    chk(out_zero,  e_z, "R5", "out_zero");
    chk(out_ovf,   e_o, "R4", "out_ovf");
  endtask

  // one cycle: check last cycle's result, then drive this cycle's inputs
  task automatic step(input logic v, input logic b, input logic s, input logic l,
                      input logic xb, input logic xd, input logic xz, input logic xo,
                      input string tag);
    @(negedge clk);
    compare_now();
    in_valid = v; in_bit = b; in_start = s; in_last = l;
    e_v = v; e_b = xb; e_d = xd; e_z = xz; e_o = xo; e_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic send_word(input logic [W-1:0] x, input int gap, input string tag);
    logic [W-1:0] neg;
    logic is_min, is_zero;
    neg = ~x + 1'b1;
    is_zero = (x == '0);
    is_min  = (x == {1'b1, {(W-1){1'b0}}});
    for (int i = 0; i < W; i++) begin
      step(1, x[i], i == 0, i == W-1, neg[i],
           i == W-1, (i == W-1) && is_zero, (i == W-1) && is_min, tag);
      if (i < W-1 && gap > 0) idle(gap);
    end
  endtask

  initial begin
    // R9: outputs held low in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_now();
    rst = 1'b0;

    send_word(8'h3C, 0, "R1");   // zeros before the first one copied
    send_word(8'h05, 0, "R2");   // inverts after the first one -> 0xFB
    send_word(8'h00, 0, "R5");   // zero word, back to back
    send_word(8'h80, 0, "R4");   // most negative, back to back
    send_word(8'h00, 0, "R8");   // start must clear state after 0x80
    send_word(8'hFF, 0, "R8");
    send_word(8'h80, 0, "R4");
    send_word(8'h01, 0, "R3");
    send_word(8'h7F, 0, "R3");
    idle(2);
    send_word(8'h3C, 1, "R10");  // gaps inside a word
    send_word(8'h80, 2, "R10");
    send_word(8'h00, 3, "R10");
    send_word(8'hA6, 1, "R10");
    idle(1);
    for (int v = 0; v < 256; v++) send_word(v[W-1:0], 0, "R3");
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule